// File: doc/BRIEF.md
# Shared interrupt source conditioner

This block takes a parameterised group of external interrupt lines (64 by default) and turns each one into a clean pending flag. Every line first passes through a two-flop synchroniser. It is then qualified by three per-line configuration bits: an active-level/edge-direction bit, a level/edge selector and a both-edges enable. In edge mode a sticky latch records each qualifying transition. Software can also set or clear that latch directly through one write port.

A per-line enable vector gates the pending flags. Software changes the enables only through separate write-one-to-set and write-one-to-clear ports, and reads them back through a read-only view. Each enabled, pending line is steered by its own route register to one of the core interrupt outputs, to the non-maskable output, or to the auxiliary output. Any output is the OR of every line currently steered to it.

Access uses a plain 32-bit register bus with a word address, a write strobe, write data and combinational read data. Address bits [ADDR_W-1:ADDR_W-4] select a region: 0 level/direction, 1 level/edge, 2 both-edges, 3 latch write, 4 enable set, 5 enable clear, 6 enable view, 7 pending view, 8 route registers. The low ADDR_W-4 bits give the word index, or the line number for region 8. Regions 3, 4 and 5 read as 0.

Top module: `shint_conditioner`

## Requirements
- R1: After reset the level/direction, level/edge and both-edges words, the enable words and all latches are 0, and every output is deasserted.
- R2: Line n is held in word n/32 at bit n%32 of the vector regions (0, 1, 2, 4, 5, 6, 7). The configuration words read back what was written.
- R3: In level mode (level/edge bit 0) a line is pending while its synchronised input equals its direction bit: high when the bit is 1, low when it is 0.
- R4: In edge mode with both-edges 0, a transition toward the direction bit's value sets the line's latch. A transition away from that value does not set it. A set latch stays set after the input returns, until software clears it, and the pending flag follows the latch.
- R5: In edge mode with both-edges 1, a rising transition and a falling transition each set the latch.
- R6: A write to region 3 addresses line wdata[5:0]. With wdata[31]=1 it sets that line's latch, and with wdata[31]=0 it clears it. A hardware edge detected in the same cycle as a clear leaves the latch set.
- R7: In a write to region 4, each 1 bit enables its line. In a write to region 5, each 1 bit disables its line. Bits written as 0 leave their lines unchanged. Region 6 reads the enables back.
- R8: Region 7 reads the pending flags of all lines, including disabled ones.
- R9: A route register holds bit 31 (steer to a core output), bit 30 (steer to the non-maskable output), bit 29 (steer to the auxiliary output) and bits 5:0 (core output number). It reads back with all other bits 0. A core output number at or above NUM_PINS reaches no core output.
- R10: The three steering bits act independently, so a single line can drive a core output, the non-maskable output and the auxiliary output together.
- R11: An output is high exactly while at least one enabled, pending line is steered to it. With no line enabled, all outputs are low.
- R12: A change on an input line reaches a level-mode pending flag two clock edges later, and reaches an edge latch three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_addr | input | ADDR_W | Word address: region in the top 4 bits, index below |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_irq | output | NUM_PINS | Core interrupt outputs |
| nmi_irq | output | 1 | Non-maskable interrupt output |
| yq_irq | output | 1 | Auxiliary interrupt output |

## Verification
The hardest case to reach is a software clear that lands in the same cycle as a hardware edge on the same line. The detection exists for only one cycle, three edges after the input changes. The stimulus raises a rising-edge line, counts two falling clock edges and only then starts the latch-clear write. The write strobe is therefore sampled on the edge that also captures the detected transition, and the latch must read as set afterwards. The other sticky-latch cases are reached by returning the input to its idle level before the clear, so a latch that merely follows the input gives a wrong reading.

// File: rtl/shint_pkg.sv
// Shared constants and types for the shared interrupt source conditioner.
// Assumes a 32-bit register bus and a 4-bit region field at the top of the address.
package shint_pkg;
    localparam int REG_W    = 32;
    localparam int REGION_W = 4;
    localparam int PINNUM_W = 6;
    localparam int BIT_PIN  = 31;
    localparam int BIT_NMI  = 30;
    localparam int BIT_YQ   = 29;
    localparam int BIT_SETL = 31;

    typedef enum logic [REGION_W-1:0] {
        RG_DIR   = 4'd0,
        RG_MODE  = 4'd1,
        RG_BOTH  = 4'd2,
        RG_LATCH = 4'd3,
        RG_ESET  = 4'd4,
        RG_ECLR  = 4'd5,
        RG_EVIEW = 4'd6,
        RG_PVIEW = 4'd7,
        RG_ROUTE = 4'd8
    } region_e;

    typedef struct packed {
        logic                to_pin;
        logic                to_nmi;
        logic                to_yq;
        logic [PINNUM_W-1:0] pin;
    } route_t;
endpackage

// File: rtl/shint_sync.sv
// Two-flop synchroniser for W asynchronous lines, plus a one-cycle-delayed copy
// of the synchronised value for transition detection. Assumes lines are
// independent (no bus coherency needed).
module shint_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_sync,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] stage1;

    // Resample the lines and keep the previous synchronised value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
            q_prev <= '0;
        end else begin
            stage1 <= d_in;
            q_sync <= stage1;
            q_prev <= q_sync;
        end
    end
endmodule

// File: rtl/shint_regs.sv
// Register file: per-line configuration, enable vector, route registers,
// latch-write decode and the combinational read mux. Assumes 2**(ADDR_W-4)
// is at least NUM_LINES.
module shint_regs
    import shint_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          we,
    input  logic [REG_W-1:0]              wdata,
    input  logic [NUM_LINES-1:0]          pend,
    output logic [NUM_LINES-1:0]          dir_q,
    output logic [NUM_LINES-1:0]          mode_q,
    output logic [NUM_LINES-1:0]          both_q,
    output logic [NUM_LINES-1:0]          enable_q,
    output route_t [NUM_LINES-1:0]        route_q,
    output logic                          latch_wr,
    output logic                          latch_set,
    output logic [$clog2(NUM_LINES)-1:0]  latch_idx,
    output logic [REG_W-1:0]              rdata
);
    localparam int IDX_W     = ADDR_W - REGION_W;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int NUM_WORDS = (NUM_LINES + REG_W - 1) / REG_W;
    localparam int PAD_W     = NUM_WORDS * REG_W;

    logic [REGION_W-1:0]  region;
    logic [IDX_W-1:0]     idx;
    logic [PAD_W-1:0]     wvec;
    logic [NUM_LINES-1:0] wline;
    logic [NUM_LINES-1:0] wsel;
    logic [NUM_LINES-1:0] eset_vec;
    logic [NUM_LINES-1:0] eclr_vec;

    assign region = addr[ADDR_W-1 -: REGION_W];
    assign idx    = addr[IDX_W-1:0];

    function automatic logic [PAD_W-1:0] widen(input logic [NUM_LINES-1:0] v);
        logic [PAD_W-1:0] r;
        r = '0;
        r[NUM_LINES-1:0] = v;
        return r;
    endfunction

    // Place the write data at the addressed word; a word index out of range selects nothing.
    always_comb begin
        wvec = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (int'(idx) == w) wvec[w*REG_W +: REG_W] = wdata;
        end
        wline = wvec[NUM_LINES-1:0];
        wsel  = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            wsel[l] = (int'(idx) == l / REG_W);
        end
    end

    assign eset_vec  = (we && region == RG_ESET) ? wline : '0;
    assign eclr_vec  = (we && region == RG_ECLR) ? wline : '0;
    assign latch_wr  = we && (region == RG_LATCH) && (int'(wdata[LINE_W-1:0]) < NUM_LINES);
    assign latch_set = wdata[BIT_SETL];
    assign latch_idx = wdata[LINE_W-1:0];

    // Configuration words and enable vector updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            mode_q   <= '0;
            both_q   <= '0;
            enable_q <= '0;
        end else begin
            if (we && region == RG_DIR)  dir_q  <= (dir_q  & ~wsel) | (wline & wsel);
            if (we && region == RG_MODE) mode_q <= (mode_q & ~wsel) | (wline & wsel);
            if (we && region == RG_BOTH) both_q <= (both_q & ~wsel) | (wline & wsel);
            enable_q <= (enable_q | eset_vec) & ~eclr_vec;
        end
    end

    // Route registers, one per line, indexed directly by the low address bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else if (we && region == RG_ROUTE) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if (int'(idx) == l) begin
                    route_q[l] <= '{to_pin: wdata[BIT_PIN], to_nmi: wdata[BIT_NMI],
                                    to_yq: wdata[BIT_YQ], pin: wdata[PINNUM_W-1:0]};
                end
            end
        end
    end

    // Read mux over regions and word indices.
    always_comb begin
        logic [PAD_W-1:0] view;
        view  = '0;
        rdata = '0;
        case (region)
            RG_DIR:   view = widen(dir_q);
            RG_MODE:  view = widen(mode_q);
            RG_BOTH:  view = widen(both_q);
            RG_EVIEW: view = widen(enable_q);
            RG_PVIEW: view = widen(pend);
            default:  view = '0;
        endcase
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (int'(idx) == w) rdata = view[w*REG_W +: REG_W];
        end
        if (region == RG_ROUTE) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if (int'(idx) == l) begin
                    rdata[BIT_PIN]        = route_q[l].to_pin;
                    rdata[BIT_NMI]        = route_q[l].to_nmi;
                    rdata[BIT_YQ]         = route_q[l].to_yq;
                    rdata[PINNUM_W-1:0]   = route_q[l].pin;
                end
            end
        end
    end

    AST_CFG_RESET: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0 && mode_q == '0 && both_q == '0 && enable_q == '0)); // R1

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eset_vec) != '0 && $past(eclr_vec) == '0)
            |-> ((enable_q & $past(eset_vec)) == $past(eset_vec))); // R7

    AST_ENABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eclr_vec) != '0) |-> ((enable_q & $past(eclr_vec)) == '0)); // R7
endmodule

// File: rtl/shint_detect.sv
// Per-line qualification: level comparison, transition detection into sticky
// latches with software set/clear, and the pending flag. Assumes q_sync/q_prev
// come from a synchroniser one cycle apart.
module shint_detect #(
    parameter int NUM_LINES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LINES-1:0]         q_sync,
    input  logic [NUM_LINES-1:0]         q_prev,
    input  logic [NUM_LINES-1:0]         dir_q,
    input  logic [NUM_LINES-1:0]         mode_q,
    input  logic [NUM_LINES-1:0]         both_q,
    input  logic                         latch_wr,
    input  logic                         latch_set,
    input  logic [$clog2(NUM_LINES)-1:0] latch_idx,
    output logic [NUM_LINES-1:0]         pend
);
    logic [NUM_LINES-1:0] latch_q;
    logic [NUM_LINES-1:0] hw_det;
    logic [NUM_LINES-1:0] sw_set;
    logic [NUM_LINES-1:0] sw_clr;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] fall;

    assign rise   = q_sync & ~q_prev;
    assign fall   = ~q_sync & q_prev;
    assign hw_det = mode_q & ((both_q & (rise | fall)) |
                              (~both_q & dir_q & rise) |
                              (~both_q & ~dir_q & fall));

    // Decode the software latch write into one-hot set and clear vectors.
    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (latch_wr && int'(latch_idx) == l) begin
                sw_set[l] = latch_set;
                sw_clr[l] = !latch_set;
            end
        end
    end

    // Sticky latches: hardware detection and software set override a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q & ~sw_clr) | sw_set | hw_det;
    end

    assign pend = (mode_q & latch_q) | (~mode_q & ~(q_sync ^ dir_q));

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(latch_wr) |-> ((latch_q & $past(latch_q)) == $past(latch_q))); // R4

    AST_HW_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hw_det) != '0) |-> ((latch_q & $past(hw_det)) == $past(hw_det))); // R6
endmodule

// File: rtl/shint_route.sv
// Steers enabled pending lines to the core outputs, the non-maskable output and
// the auxiliary output; each output ORs all lines steered to it.
module shint_route
    import shint_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_PINS  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   active,
    input  route_t [NUM_LINES-1:0] route_q,
    output logic [NUM_PINS-1:0]    core_irq,
    output logic                   nmi_irq,
    output logic                   yq_irq
);
    // OR every active line into the outputs its route register selects.
    always_comb begin
        core_irq = '0;
        nmi_irq  = 1'b0;
        yq_irq   = 1'b0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (active[l]) begin
                nmi_irq = nmi_irq | route_q[l].to_nmi;
                yq_irq  = yq_irq  | route_q[l].to_yq;
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (route_q[l].to_pin && int'(route_q[l].pin) == p) core_irq[p] = 1'b1;
                end
            end
        end
    end

    AST_OUT_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq != '0 || nmi_irq || yq_irq) |-> (active != '0)); // R11
endmodule

// File: rtl/shint_conditioner.sv
// Top of the shared interrupt source conditioner: synchroniser, register file,
// detection and routing. Assumes a synchronous active-low reset and asynchronous
// interrupt lines.
module shint_conditioner
    import shint_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_PINS  = 6,
    parameter int ADDR_W    = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_PINS-1:0]  core_irq,
    output logic                 nmi_irq,
    output logic                 yq_irq
);
    localparam int LINE_W = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0]   q_sync, q_prev;
    logic [NUM_LINES-1:0]   dir_q, mode_q, both_q, enable_q, pend;
    route_t [NUM_LINES-1:0] route_q;
    logic                   latch_wr, latch_set;
    logic [LINE_W-1:0]      latch_idx;

    shint_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(irq_lines), .q_sync(q_sync), .q_prev(q_prev)
    );

    shint_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .pend(pend), .dir_q(dir_q), .mode_q(mode_q), .both_q(both_q),
        .enable_q(enable_q), .route_q(route_q), .latch_wr(latch_wr),
        .latch_set(latch_set), .latch_idx(latch_idx), .rdata(bus_rdata)
    );

    shint_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .q_sync(q_sync), .q_prev(q_prev), .dir_q(dir_q),
        .mode_q(mode_q), .both_q(both_q), .latch_wr(latch_wr), .latch_set(latch_set),
        .latch_idx(latch_idx), .pend(pend)
    );

    shint_route #(.NUM_LINES(NUM_LINES), .NUM_PINS(NUM_PINS)) u_route (
        .clk(clk), .rst_n(rst_n), .active(pend & enable_q), .route_q(route_q),
        .core_irq(core_irq), .nmi_irq(nmi_irq), .yq_irq(yq_irq)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> (core_irq == '0 && !nmi_irq && !yq_irq)); // R11
endmodule

// File: tb/test_shint_conditioner.sv
module test_shint_conditioner;
    localparam int NL = 64;
    localparam int NP = 6;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lines = '0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] core_irq;
    logic          nmi_irq, yq_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    shint_conditioner #(.NUM_LINES(NL), .NUM_PINS(NP), .ADDR_W(AW)) i_shint_conditioner (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .core_irq(core_irq),
        .nmi_irq(nmi_irq), .yq_irq(yq_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int region, input int idx, input logic [31:0] d);
        @(negedge clk);
        addr  = AW'((region << 6) | idx);
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input int region, input int idx, output logic [31:0] d);
        addr = AW'((region << 6) | idx);
        #1;
        d = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 0, v); check(v == 0, "R1 dir word0", v, 0);
        rd(1, 1, v); check(v == 0, "R1 mode word1", v, 0);
        rd(2, 0, v); check(v == 0, "R1 both word0", v, 0);
        rd(6, 1, v); check(v == 0, "R1 enable word1", v, 0);
        check(core_irq == 0 && !nmi_irq && !yq_irq, "R1 outputs", {24'b0, nmi_irq, yq_irq, core_irq}, 0);
        rd(7, 0, v); check(v == 32'hffff_ffff, "R8 R3 pending while disabled", v, 32'hffff_ffff);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(0, 1, 32'h0000_0020);
        rd(0, 1, v); check(v == 32'h20, "R2 dir word1 readback", v, 32'h20);
        rd(7, 1, v); check(v == 32'hffff_ffdf, "R3 line37 active-high idle", v, 32'hffff_ffdf);
        lines[37] = 1'b1;
        wait_n(1);
        rd(7, 1, v); check(v[5] == 1'b0, "R12 level not yet after one edge", {31'b0, v[5]}, 0);
        wait_n(1);
        rd(7, 1, v); check(v[5] == 1'b1, "R12 R3 level after two edges", {31'b0, v[5]}, 1);
        lines[37] = 1'b0;
        wait_n(2);
        rd(7, 1, v); check(v[5] == 1'b0, "R3 level released", {31'b0, v[5]}, 0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(0, 0, 32'h0000_0008);
        wr(1, 0, 32'h0000_0018);
        rd(7, 0, v); check(v[4:3] == 2'b00, "R4 edge lines idle", {30'b0, v[4:3]}, 0);
        lines[3] = 1'b1;
        wait_n(2);
        rd(7, 0, v); check(v[3] == 1'b0, "R12 latch not yet after two edges", {31'b0, v[3]}, 0);
        wait_n(1);
        rd(7, 0, v); check(v[3] == 1'b1, "R12 R4 rising latched", {31'b0, v[3]}, 1);
        lines[3] = 1'b0;
        wait_n(4);
        rd(7, 0, v); check(v[3] == 1'b1, "R4 latch sticky after input falls", {31'b0, v[3]}, 1);
        wr(3, 0, 32'h0000_0003);
        rd(7, 0, v); check(v[3] == 1'b0, "R6 software clear", {31'b0, v[3]}, 0);
        lines[4] = 1'b1;
        wait_n(4);
        rd(7, 0, v); check(v[4] == 1'b0, "R4 wrong-direction edge ignored", {31'b0, v[4]}, 0);
        lines[4] = 1'b0;
        wait_n(3);
        rd(7, 0, v); check(v[4] == 1'b1, "R4 falling edge latched", {31'b0, v[4]}, 1);
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(1, 0, 32'h0000_0058);
        wr(2, 0, 32'h0000_0040);
        lines[6] = 1'b1;
        wait_n(3);
        rd(7, 0, v); check(v[6] == 1'b1, "R5 rising latched", {31'b0, v[6]}, 1);
        wr(3, 0, 32'h0000_0006);
        rd(7, 0, v); check(v[6] == 1'b0, "R5 cleared", {31'b0, v[6]}, 0);
        lines[6] = 1'b0;
        wait_n(3);
        rd(7, 0, v); check(v[6] == 1'b1, "R5 falling latched", {31'b0, v[6]}, 1);
    endtask

    task automatic t_soft();
        logic [31:0] v;
        wr(0, 1, 32'h0000_0100);
        wr(1, 1, 32'h0000_0100);
        rd(7, 1, v); check(v[8] == 1'b0, "R6 line40 idle", {31'b0, v[8]}, 0);
        wr(3, 0, 32'h8000_0028);
        rd(7, 1, v); check(v[8] == 1'b1, "R6 software set", {31'b0, v[8]}, 1);
        wr(3, 0, 32'h0000_0028);
        rd(7, 1, v); check(v[8] == 1'b0, "R6 software clear", {31'b0, v[8]}, 0);
        lines[40] = 1'b1;
        wait_n(1);
        wr(3, 0, 32'h0000_0028);
        rd(7, 1, v); check(v[8] == 1'b1, "R6 hardware edge beats clear", {31'b0, v[8]}, 1);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(4, 0, 32'h0000_00f0);
        rd(6, 0, v); check(v == 32'hf0, "R7 set", v, 32'hf0);
        wr(4, 0, 32'h0000_0f00);
        rd(6, 0, v); check(v == 32'hff0, "R7 set keeps others", v, 32'hff0);
        wr(5, 0, 32'h0000_0030);
        rd(6, 0, v); check(v == 32'hfc0, "R7 clear", v, 32'hfc0);
        wr(5, 1, 32'h0000_0000);
        rd(6, 0, v); check(v == 32'hfc0, "R7 zero clear no effect", v, 32'hfc0);
        wr(5, 0, 32'hffff_ffff);
        rd(6, 0, v); check(v == 0, "R7 clear all", v, 0);
    endtask

    task automatic t_route();
        logic [31:0] v;
        wr(8, 0, 32'h8000_0002);
        rd(8, 0, v); check(v == 32'h8000_0002, "R9 route readback", v, 32'h8000_0002);
        check(core_irq == 0, "R11 disabled line silent", {26'b0, core_irq}, 0);
        wr(4, 0, 32'h0000_0001);
        check(core_irq == 6'b000100 && !nmi_irq, "R9 R11 pin 2 asserted", {24'b0, nmi_irq, yq_irq, core_irq}, 32'h04);
        wr(8, 1, 32'hc000_0002);
        wr(4, 0, 32'h0000_0002);
        check(core_irq == 6'b000100 && nmi_irq && !yq_irq, "R10 pin and nmi", {24'b0, nmi_irq, yq_irq, core_irq}, 32'h84);
        wr(5, 0, 32'h0000_0001);
        check(core_irq == 6'b000100, "R11 OR of lines", {26'b0, core_irq}, 32'h04);
        wr(8, 1, 32'ha000_0009);
        check(core_irq == 0 && !nmi_irq && yq_irq, "R9 R10 pin out of range, yq", {24'b0, nmi_irq, yq_irq, core_irq}, 32'h40);
        wr(8, 1, 32'h0000_0003);
        check(core_irq == 0 && !nmi_irq && !yq_irq, "R9 no steering bit", {24'b0, nmi_irq, yq_irq, core_irq}, 0);
        wr(8, 1, 32'h8000_0005);
        check(core_irq == 6'b100000, "R9 pin 5", {26'b0, core_irq}, 32'h20);
        lines[1] = 1'b1;
        wait_n(2);
        check(core_irq == 0, "R11 line no longer pending", {26'b0, core_irq}, 0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_level();
        t_edge();
        t_both();
        t_soft();
        t_enable();
        t_route();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule